// File: doc/BRIEF.md
# Stereo Sample FIFO Interrupt Controller

This block buffers audio samples for two playback channels, A and B. Each channel has its own sample queue, 1024 entries deep by default. A host fills the queues through a simple register write port. A fixed-rate playback tick takes one sample from each queue that is not empty and presents it on a per-channel output.

Each channel produces two events. The full event fires when the queue reaches capacity, and fires again on any write that arrives while the queue is full. The half-empty event fires when the fill level drops from half to one below half. Events are latched into a status register that clears when the host reads it. A single level interrupt output is high whenever any status bit is set.

Each channel has a mask register that gates its half-empty event. Clearing the mask while the channel is already below half raises the event straight away.

Top module: `stereo_fifo_irq`

## Requirements
- R1: Each channel queue accepts exactly DEPTH (default 1024) samples from empty with no playback, and plays them back in write order. While playback drains the queue during filling, more than DEPTH writes are accepted before the full event.
- R2: Register addresses: 0 writes a channel A sample, 1 writes a channel B sample, 2 reads status, 3 is the channel A mask (read/write), 4 is the channel B mask (read/write), and 5 reads the empty flags (bit 0 for A, bit 1 for B). Reads of any other address return 0. Status bit 0 is A half-empty, bit 1 is A full, bit 2 is B half-empty and bit 3 is B full.
- R3: A status read returns the latched bits and clears them in the same access. The interrupt output is the OR of the status bits and stays high until that read.
- R4: The full event latches when a queue's count reaches DEPTH. A write to a full queue discards the sample and latches the full event again.
- R5: The half-empty event latches once, on the count step from DEPTH/2 to DEPTH/2-1. It does not latch again while the level stays below half.
- R6: The half-empty event of a channel latches only while that channel's mask holds 0. A crossing that happens while the mask is nonzero is dropped. Masks read back the written value.
- R7: Writing 0 to a channel's mask while its count is below DEPTH/2 latches that channel's half-empty bit at once.
- R8: After the level rises back to DEPTH/2, a new step down to DEPTH/2-1 latches the half-empty event again.
- R9: Channel events latch independently. Channel A reaching full while channel B is one short reads as 0x02.
- R10: A playback tick removes one sample from each non-empty queue and raises that channel's play-valid output one cycle later. A tick has no effect on an empty queue, and no play-valid is raised for it.
- R11: After reset the counts are 0, status is 0, both masks are 0, the interrupt is low and both empty flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clear takes effect at the clock edge) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from current state |
| play_tick | input | 1 | Playback rate strobe |
| play_valid_a | output | 1 | Channel A sample presented |
| play_data_a | output | 8 | Channel A sample |
| play_valid_b | output | 1 | Channel B sample presented |
| play_data_b | output | 8 | Channel B sample |
| irq | output | 1 | Level interrupt, OR of the status bits |

## Verification
The hardest conditions to reach from the ports need a channel's fill level held exactly at the half boundary while its mask or its partner channel is in a chosen state. Examples are a crossing that happens while masked, followed by unmasking below half, and a crossing that re-arms after a refill to exactly half.

The stimulus reaches these states by counting writes and ticks from a known empty queue, so the level at each step is known in the bench. The same counting reaches the channel-skew state: both queues are filled to one short of full before one final write to A alone. The drain-while-filling case uses a fixed tick pattern, and the bench computes the expected number of accepted writes before full with its own occupancy model.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    localparam int NCH = 2;
    localparam int AW  = 3;

    typedef enum logic [AW-1:0] {
        ADDR_DATA_A = 3'd0,
        ADDR_DATA_B = 3'd1,
        ADDR_STATUS = 3'd2,
        ADDR_MASK_A = 3'd3,
        ADDR_MASK_B = 3'd4,
        ADDR_EMPTY  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/sfi_sample_fifo.sv
module sfi_sample_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic [DATA_W-1:0]             data_i,
    input  logic                          pop_i,
    output logic [$clog2(DEPTH):0]        cnt_q_o,
    output logic [$clog2(DEPTH):0]        cnt_d_o,
    output logic                          push_rej_o,
    output logic                          empty_o,
    output logic                          out_valid_o,
    output logic [DATA_W-1:0]             out_data_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] cnt;
        logic             out_valid;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic        do_push, do_pop;
    logic [DATA_W-1:0] store_q [DEPTH];
    logic [DATA_W-1:0] out_data_q;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != FULL_CNT);
        do_pop  = pop_i && (st_q.cnt != '0);
        if (do_push) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.out_valid = do_pop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Sample storage carries no reset.
    always_ff @(posedge clk) begin
        if (do_push) store_q[st_q.wr_ptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      out_data_q <= '0;
        else if (do_pop) out_data_q <= store_q[st_q.rd_ptr];
    end

    assign cnt_q_o     = st_q.cnt;
    assign cnt_d_o     = st_d.cnt;
    assign push_rej_o  = push_i && (st_q.cnt == FULL_CNT);
    assign empty_o     = (st_q.cnt == '0);
    assign out_valid_o = st_q.out_valid;
    assign out_data_o  = out_data_q;
endmodule

// File: rtl/sfi_chan_events.sv
module sfi_chan_events #(
    parameter int DEPTH  = 1024,
    parameter int MASK_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] cnt_q_i,
    input  logic [$clog2(DEPTH):0] cnt_d_i,
    input  logic                   push_rej_i,
    input  logic                   mask_wr_i,
    input  logic [MASK_W-1:0]      mask_wdata_i,
    output logic [MASK_W-1:0]      mask_q_o,
    output logic                   half_evt_o,
    output logic                   full_evt_o
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    typedef struct packed {
        logic [MASK_W-1:0] mask;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic       crossing, unmask_now, below_half;

    always_comb begin
        st_d = st_q;
        if (mask_wr_i) st_d.mask = mask_wdata_i;
        below_half = (cnt_d_i < HALF_CNT);
        crossing   = (cnt_q_i >= HALF_CNT) && below_half;
        unmask_now = mask_wr_i && (mask_wdata_i == '0) && below_half;
        half_evt_o = (st_d.mask == '0) && (crossing || unmask_now);
        full_evt_o = ((cnt_d_i == FULL_CNT) && (cnt_q_i != FULL_CNT)) || push_rej_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q_o = st_q.mask;
endmodule

// File: rtl/sfi_irq_status.sv
module sfi_irq_status #(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*NCH-1:0] evt_i,
    input  logic             clr_i,
    output logic [2*NCH-1:0] status_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [2*NCH-1:0] bits;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // An event at the same edge as the clearing read survives it.
        st_d.bits = (clr_i ? '0 : st_q.bits) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;
    assign irq_o    = |st_q.bits;
endmodule

// File: rtl/stereo_fifo_irq.sv
module stereo_fifo_irq
    import sfi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              play_tick,
    output logic              play_valid_a,
    output logic [DATA_W-1:0] play_data_a,
    output logic              play_valid_b,
    output logic [DATA_W-1:0] play_data_b,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [CNT_W-1:0]  cnt_q     [NCH];
    logic [CNT_W-1:0]  cnt_d     [NCH];
    logic [DATA_W-1:0] mask_q    [NCH];
    logic [DATA_W-1:0] play_data [NCH];
    logic [NCH-1:0]    play_valid;
    logic [NCH-1:0]    empty;
    logic [NCH-1:0]    push_rej;
    logic [2*NCH-1:0]  evt;
    logic [2*NCH-1:0]  status_q;
    logic              status_clr;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam logic [AW-1:0] DATA_ADR = AW'(int'(ADDR_DATA_A) + g);
        localparam logic [AW-1:0] MASK_ADR = AW'(int'(ADDR_MASK_A) + g);

        logic push, mask_wr;
        assign push    = reg_wr && (reg_addr == DATA_ADR);
        assign mask_wr = reg_wr && (reg_addr == MASK_ADR);

        sfi_sample_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (push),
            .data_i      (reg_wdata),
            .pop_i       (play_tick),
            .cnt_q_o     (cnt_q[g]),
            .cnt_d_o     (cnt_d[g]),
            .push_rej_o  (push_rej[g]),
            .empty_o     (empty[g]),
            .out_valid_o (play_valid[g]),
            .out_data_o  (play_data[g])
        );

        sfi_chan_events #(
            .DEPTH  (DEPTH),
            .MASK_W (DATA_W)
        ) u_evt (
            .clk          (clk),
            .rst_n        (rst_n),
            .cnt_q_i      (cnt_q[g]),
            .cnt_d_i      (cnt_d[g]),
            .push_rej_i   (push_rej[g]),
            .mask_wr_i    (mask_wr),
            .mask_wdata_i (reg_wdata),
            .mask_q_o     (mask_q[g]),
            .half_evt_o   (evt[2*g]),
            .full_evt_o   (evt[2*g+1])
        );
    end

    assign status_clr = reg_rd && (reg_addr == ADDR_STATUS);

    sfi_irq_status #(
        .NCH (NCH)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .clr_i    (status_clr),
        .status_o (status_q),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_STATUS: reg_rdata = DATA_W'(status_q);
            ADDR_MASK_A: reg_rdata = mask_q[0];
            ADDR_MASK_B: reg_rdata = mask_q[1];
            ADDR_EMPTY:  reg_rdata = DATA_W'(empty);
            default:     reg_rdata = '0;
        endcase
    end

    assign play_valid_a = play_valid[0];
    assign play_data_a  = play_data[0];
    assign play_valid_b = play_valid[1];
    assign play_data_b  = play_data[1];
endmodule

// File: rtl/stereo_fifo_irq_chk.sv
module stereo_fifo_irq_chk #(
    parameter int DEPTH = 1024
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic                   reg_rd,
    input logic [2:0]             reg_addr,
    input logic                   play_tick,
    input logic                   irq,
    input logic                   play_valid_a,
    input logic [$clog2(DEPTH):0] cnt_a,
    input logic [$clog2(DEPTH):0] cnt_b,
    input logic [3:0]             status,
    input logic [7:0]             mask_a
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_a <= FULL_CNT) && (cnt_b <= FULL_CNT));

    assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_rd && reg_addr == 3'd2)) |=> irq);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd2 && !reg_wr && !play_tick) |=> !irq);

    assert_full_rewrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && cnt_a == FULL_CNT) |=> status[1]);

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a != 8'd0 && !reg_wr && !status[0]) |=> !status[0]);

    assert_empty_no_play_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (play_tick && cnt_a == '0) |=> !play_valid_a);
endmodule

bind stereo_fifo_irq stereo_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .play_tick    (play_tick),
    .irq          (irq),
    .play_valid_a (play_valid_a),
    .cnt_a        (cnt_q[0]),
    .cnt_b        (cnt_q[1]),
    .status       (status_q),
    .mask_a       (mask_q[0])
);

// File: tb/tb_stereo_fifo_irq.sv
`timescale 1ns/1ps
module tb_stereo_fifo_irq;
    localparam int DEPTH = 1024;
    localparam int HALF  = DEPTH / 2;
    localparam real CLK_PERIOD = 8.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, play_tick = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata, play_data_a, play_data_b;
    logic       play_valid_a, play_valid_b, irq;
    logic [7:0] rd_s;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    stereo_fifo_irq #(.DATA_W(8), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .play_tick(play_tick),
        .play_valid_a(play_valid_a), .play_data_a(play_data_a),
        .play_valid_b(play_valid_b), .play_data_b(play_data_b),
        .irq(irq)
    );

    localparam logic [2:0] A_DAT = 3'd0, B_DAT = 3'd1, STAT = 3'd2,
                           A_MSK = 3'd3, B_MSK = 3'd4, EMPT = 3'd5;

    // Vector layout: kind(2) addr(3) data(8) expected(8).
    // kind 0 = register write, 1 = register read and compare, 2 = irq compare.
    localparam int NVEC = 15;
    localparam logic [20:0] VEC [NVEC] = '{
        {2'd0, A_MSK, 8'h5A, 8'h00},   // R6 write mask A
        {2'd0, B_MSK, 8'h33, 8'h00},   // R6 write mask B
        {2'd1, A_MSK, 8'h00, 8'h5A},   // R6 mask A read back
        {2'd1, B_MSK, 8'h00, 8'h33},   // R6 mask B read back
        {2'd1, EMPT,  8'h00, 8'h03},   // R11 both empty
        {2'd1, STAT,  8'h00, 8'h00},   // R11 status clear
        {2'd1, 3'd7,  8'h00, 8'h00},   // R2 unused address
        {2'd2, 3'd0,  8'h00, 8'h00},   // R11 irq low
        {2'd0, A_MSK, 8'h00, 8'h00},   // R7 unmask A below half
        {2'd2, 3'd0,  8'h00, 8'h01},   // R7 irq raised
        {2'd1, STAT,  8'h00, 8'h01},   // R7 bit 0 latched
        {2'd1, STAT,  8'h00, 8'h00},   // R3 cleared by read
        {2'd0, B_MSK, 8'h00, 8'h00},   // R7 unmask B below half
        {2'd1, STAT,  8'h00, 8'h04},   // R2 bit 2 for B half-empty
        {2'd2, 3'd0,  8'h00, 8'h00}    // R3 irq dropped after read
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic op(input logic wr, input logic rd, input logic [2:0] addr,
                      input logic [7:0] data, input logic tick);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = data; play_tick = tick;
        #1;
        rd_s = reg_rdata;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0; play_tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] addr, input logic [7:0] data);
        op(1'b1, 1'b0, addr, data, 1'b0);
    endtask

    task automatic tick();
        op(1'b0, 1'b0, 3'd0, 8'd0, 1'b1);
    endtask

    task automatic rd_check(input string tag, input logic [2:0] addr, input logic [7:0] exp);
        op(1'b0, 1'b1, addr, 8'd0, 1'b0);
        check(tag, rd_s, exp);
    endtask

    initial begin
        repeat (1_000_000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int bad;
        int model;
        int n;
        int predicted;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state at the ports
        check("R11 irq after reset", irq, 0);
        check("R11 no playback after reset", play_valid_a | play_valid_b, 0);

        // Register-level vector walk (R2 R3 R6 R7 R11)
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] kind;
            logic [2:0] a;
            logic [7:0] d, e;
            {kind, a, d, e} = VEC[i];
            case (kind)
                2'd0: wr(a, d);
                2'd1: begin
                    op(1'b0, 1'b1, a, 8'd0, 1'b0);
                    check($sformatf("R2 R6 R7 vector %0d read", i), rd_s, e);
                end
                default: check($sformatf("R3 R7 vector %0d irq", i), irq, e[0]);
            endcase
        end

        // R1 R4 R9: fill A alone from empty
        for (int i = 0; i < DEPTH - 1; i++) wr(A_DAT, 8'(i));
        check("R4 no full before last slot", irq, 0);
        wr(A_DAT, 8'(DEPTH - 1));
        check("R1 full after DEPTH writes", irq, 1);
        rd_check("R9 only A full", STAT, 8'h02);
        check("R3 irq low after read", irq, 0);
        rd_check("R10 empty flags A filled", EMPT, 8'h02);
        wr(A_DAT, 8'hEE);
        rd_check("R4 write to full re-raises", STAT, 8'h02);

        // R1 R5 R10: drain A, checking order and single crossing
        bad = 0;
        for (int k = 0; k < HALF; k++) begin
            tick();
            if (!play_valid_a || play_data_a !== 8'(k) || play_valid_b) bad++;
        end
        check("R1 order first half", bad, 0);
        check("R5 no event at half", irq, 0);
        tick();
        check("R1 sample at half", play_data_a, 8'(HALF));
        rd_check("R5 half-empty on crossing", STAT, 8'h01);
        bad = 0;
        for (int k = HALF + 1; k < DEPTH; k++) begin
            tick();
            if (!play_valid_a || play_data_a !== 8'(k)) bad++;
        end
        check("R1 order second half, discarded sample absent", bad, 0);
        check("R5 no repeat while below half", irq, 0);
        rd_check("R10 empty again", EMPT, 8'h03);
        tick();
        check("R10 tick on empty plays nothing", play_valid_a | play_valid_b, 0);
        rd_check("R10 tick on empty leaves state", STAT, 8'h00);

        // R6 R7: masked crossing is dropped, unmask below half fires
        wr(A_MSK, 8'h01);
        for (int i = 0; i < 600; i++) wr(A_DAT, 8'(i));
        repeat (100) tick();
        check("R6 masked crossing no irq", irq, 0);
        rd_check("R6 masked crossing not latched", STAT, 8'h00);
        wr(A_MSK, 8'h00);
        check("R7 unmask below half raises irq", irq, 1);
        rd_check("R7 unmask latches A half", STAT, 8'h01);

        // R8: re-arm after climbing back to half (level now HALF-12)
        for (int i = 0; i < 12; i++) wr(A_DAT, 8'(i));
        check("R8 no event climbing", irq, 0);
        tick();
        rd_check("R8 first re-crossing", STAT, 8'h01);
        wr(A_DAT, 8'h11);
        tick();
        rd_check("R8 second re-crossing", STAT, 8'h01);
        repeat (HALF - 1) tick();
        rd_check("R10 A drained", EMPT, 8'h03);
        rd_check("R5 drain below half silent", STAT, 8'h00);

        // R9: interleaved fill, A finishes first
        for (int i = 0; i < DEPTH - 1; i++) begin
            wr(A_DAT, 8'(i));
            wr(B_DAT, 8'(i));
        end
        check("R9 nothing before last writes", irq, 0);
        wr(A_DAT, 8'h00);
        rd_check("R9 A full alone", STAT, 8'h02);
        wr(B_DAT, 8'h00);
        rd_check("R9 B full", STAT, 8'h08);
        repeat (HALF) tick();
        check("R9 no event at half", irq, 0);
        tick();
        check("R10 both channels play", play_valid_a & play_valid_b, 1);
        rd_check("R2 both half-empty", STAT, 8'h05);
        repeat (HALF - 1) tick();
        rd_check("R10 both drained", EMPT, 8'h03);

        // R1: fill A while playback drains it on every fourth cycle
        model = 0;
        predicted = 0;
        for (int c = 1; c < 4000 && predicted == 0; c++) begin
            if (model < DEPTH) model++;
            if ((c % 4) == 0 && model > 0) model--;
            if (model == DEPTH) predicted = c;
        end
        n = 0;
        while (!irq && n < 4000) begin
            n++;
            op(1'b1, 1'b0, A_DAT, 8'(n), (n % 4) == 0);
        end
        check("R1 writes accepted before full with drain", n, predicted);
        check("R1 more than DEPTH writes accepted", n > DEPTH, 1);
        rd_check("R4 full with drain", STAT, 8'h02);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule